// File: doc/BRIEF.md
# Pulse-Synchronized Ranging Capture Controller

This block fires the laser of a pulsed time-of-flight ranging front end and controls the receive side from that same pulse. A configuration write port sets three values: the firing period, the trigger pulse width and the length of a capture window. Each trigger pulse opens a window in which beats of the converter stream are forwarded to an AXI4-Stream output that feeds a DMA. Samples outside a window are discarded, so only the part of the return that follows each shot is stored.

The input stream is 128 bits wide on the device clock. It carries four converters of 8 bits, with four samples per converter in each clock. One sample step is 15 cm of range, because distance = N x c / (2 x fs) at fs = 1 GHz. The block also drives a 2-bit channel select shared by four 4-to-1 receive amplifier multiplexers, so 16 photodetector channels are scanned across four converter inputs. The select moves to the next channel only between windows, so every window is taken on a single channel. Window timing never waits on the output: a beat the sink is not ready for is lost and recorded in a sticky flag.

Top module: `tof_capture_ctrl`

## Requirements
- R1: While reset is asserted, and after it, the trigger is low, tvalid is low, the channel select is 0 and the overflow flag is 0.
- R2: Writing a nonzero period P to register address 0 while the block is idle starts a pulse at the next clock edge. When the window is shorter than P, successive pulses start exactly P cycles apart.
- R3: The trigger stays high for W consecutive cycles, where W is the width register (address 1). A width of P or more gives P-1 cycles, and a width of 0 gives no high cycle.
- R4: While the period register is 0, the trigger never rises and no beat is presented.
- R5: With window length L (address 2), tvalid is high for exactly L consecutive cycles, starting in the cycle the trigger rises. In each of those cycles tdata equals s_samples of the same cycle. tvalid is low in every other cycle.
- R6: tlast is 1 only on the L-th beat of a window. tuser carries the channel select on the first beat and is 0 on every other beat.
- R7: The channel select holds its value while a window is open. It rises by one, wrapping from 3 to 0, in the cycle after the last beat of each window.
- R8: A new pulse is never started while a window is open. When L >= P, successive pulses start L+1 cycles apart.
- R9: A beat offered while tready is low is lost. Later beats keep their original cycles, and the overflow flag becomes 1 and stays 1 until any write to address 3 clears it.
- R10: Period and width are captured when a pulse starts. A later register write, including setting the period to 0, does not cut short the pulse in flight.
- R11: With L = 0, pulses still fire with their period and width, but no beat is presented and the channel select does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register address: 0 period, 1 width, 2 window length, 3 overflow clear |
| cfg_wdata | input | 16 | Write data |
| s_samples | input | 128 | Converter samples for this clock (4 converters x 4 samples x 8 bits) |
| laser_trig | output | 1 | Laser trigger pulse, shared by all lasers |
| rx_chan_sel | output | 2 | Channel select shared by the four receive multiplexers |
| m_axis_tdata | output | 128 | Forwarded samples |
| m_axis_tvalid | output | 1 | Beat present (window open) |
| m_axis_tready | input | 1 | Sink ready |
| m_axis_tlast | output | 1 | Final beat of a window |
| m_axis_tuser | output | 2 | Channel select on the first beat, otherwise 0 |
| ovf_flag | output | 1 | Sticky flag for lost beats |

## Verification
The bench aims at the cases where the window and the pulse period conflict. With a window longer than the period, a design without the hold-off would fire inside an open window and the beats would come out at the wrong cycles. With a width larger than the period, an unclamped design would hold the trigger high through the next shot. A design that stalls on tready low instead of dropping would shift every later beat and would also fail the overflow flag check. Disabling the block during a pulse, using a zero-length window and wrapping the channel select past 3 are also run. These catch a trigger that is cut short, a select that advances on an empty window, and a wrong tuser on the first beat.

// File: rtl/tof_pkg.sv
package tof_pkg;

  localparam int unsigned CFG_W = 16;

  typedef logic [CFG_W-1:0] cfg_word_t;

  // Register addresses seen on the configuration port
  typedef enum logic [1:0] {
    REG_PERIOD = 2'd0,
    REG_WIDTH  = 2'd1,
    REG_WINLEN = 2'd2,
    REG_OVFCLR = 2'd3
  } cfg_addr_e;

  // Pulse width limited so that the trigger falls before the next shot
  function automatic cfg_word_t clamp_width(cfg_word_t w, cfg_word_t p);
    if (p == '0) return '0;
    return (w >= p) ? cfg_word_t'(p - 1'b1) : w;
  endfunction

  // Counter step modulo a limit (limit is nonzero)
  function automatic cfg_word_t count_step(cfg_word_t c, cfg_word_t limit);
    return (c == cfg_word_t'(limit - 1'b1)) ? '0 : cfg_word_t'(c + 1'b1);
  endfunction

  // Next receive channel in the scan order, wrapping at nch
  function automatic int unsigned next_chan(int unsigned sel, int unsigned nch);
    return (sel + 1 >= nch) ? 0 : sel + 1;
  endfunction

endpackage

// File: rtl/tof_pulse_gen.sv
module tof_pulse_gen
  import tof_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cfg_word_t period_cfg,
  input  cfg_word_t width_cfg,
  input  logic      fire_ok,
  output logic      fire,
  output logic      trig
);

  cfg_word_t pcnt;
  cfg_word_t per_q;
  cfg_word_t wid_q;
  cfg_word_t wid_eff;
  logic      trig_q;
  logic      running;

  assign running = (pcnt != '0);
  assign wid_eff = clamp_width(width_cfg, period_cfg);
  assign fire    = !running && (period_cfg != '0) && fire_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt   <= '0;
      per_q  <= '0;
      wid_q  <= '0;
      trig_q <= 1'b0;
    end else if (fire) begin
      per_q  <= period_cfg;
      wid_q  <= wid_eff;
      pcnt   <= count_step('0, period_cfg);
      trig_q <= (wid_eff != '0);
    end else if (running) begin
      pcnt   <= count_step(pcnt, per_q);
      trig_q <= (pcnt < wid_q);
    end else begin
      trig_q <= 1'b0;
    end
  end

  assign trig = trig_q;

endmodule

// File: rtl/tof_rx_window.sv
module tof_rx_window
  import tof_pkg::*;
#(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  cfg_word_t        len_cfg,
  output logic             win_open,
  output logic             win_first,
  output logic             win_last,
  output logic [SEL_W-1:0] chan_sel
);

  localparam int unsigned NCH = 1 << SEL_W;

  logic             open_q;
  cfg_word_t        idx_q;
  cfg_word_t        len_q;
  logic [SEL_W-1:0] sel_q;

  assign win_open  = open_q;
  assign win_first = open_q && (idx_q == '0);
  assign win_last  = open_q && (idx_q == cfg_word_t'(len_q - 1'b1));
  assign chan_sel  = sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      idx_q  <= '0;
      len_q  <= '0;
      sel_q  <= '0;
    end else if (fire) begin
      open_q <= (len_cfg != '0);
      idx_q  <= '0;
      len_q  <= len_cfg;
    end else if (open_q) begin
      if (win_last) begin
        open_q <= 1'b0;
        sel_q  <= SEL_W'(next_chan(int'(sel_q), NCH));
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tof_stream_gate.sv
module tof_stream_gate #(
  parameter int unsigned DW    = 128,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_open,
  input  logic             win_first,
  input  logic             win_last,
  input  logic [SEL_W-1:0] chan_sel,
  input  logic [DW-1:0]    samples,
  input  logic             tready,
  input  logic             ovf_clr,
  output logic             tvalid,
  output logic [DW-1:0]    tdata,
  output logic             tlast,
  output logic [SEL_W-1:0] tuser,
  output logic             ovf,
  output logic             drop
);

  logic ovf_q;

  assign tvalid = win_open;
  assign tdata  = win_open ? samples : '0;
  assign tlast  = win_last;
  assign tuser  = win_first ? chan_sel : '0;
  assign drop   = win_open && !tready;
  assign ovf    = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_q <= 1'b0;
    else if (drop)    ovf_q <= 1'b1;
    else if (ovf_clr) ovf_q <= 1'b0;
  end

endmodule

// File: rtl/tof_capture_ctrl.sv
module tof_capture_ctrl
  import tof_pkg::*;
#(
  parameter int unsigned NUM_CONV = 4,
  parameter int unsigned SAMP_W   = 8,
  parameter int unsigned SPC      = 4,
  parameter int unsigned SEL_W    = 2,
  localparam int unsigned DW      = NUM_CONV * SPC * SAMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [DW-1:0]    s_samples,
  output logic             laser_trig,
  output logic [SEL_W-1:0] rx_chan_sel,
  output logic [DW-1:0]    m_axis_tdata,
  output logic             m_axis_tvalid,
  input  logic             m_axis_tready,
  output logic             m_axis_tlast,
  output logic [SEL_W-1:0] m_axis_tuser,
  output logic             ovf_flag
);

  cfg_word_t period_q, width_q, winlen_q;

  // Named internal events
  logic fire_evt;
  logic win_open;
  logic win_first;
  logic win_last;
  logic beat_drop;
  logic ovf_clr;
  logic period_zero;

  assign ovf_clr     = cfg_we && (cfg_addr_e'(cfg_addr) == REG_OVFCLR);
  assign period_zero = (period_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      width_q  <= '0;
      winlen_q <= '0;
    end else if (cfg_we) begin
      case (cfg_addr_e'(cfg_addr))
        REG_PERIOD: period_q <= cfg_wdata;
        REG_WIDTH:  width_q  <= cfg_wdata;
        REG_WINLEN: winlen_q <= cfg_wdata;
        default: ;
      endcase
    end
  end

  tof_pulse_gen u_pulse (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_cfg (period_q),
    .width_cfg  (width_q),
    .fire_ok    (!win_open),
    .fire       (fire_evt),
    .trig       (laser_trig)
  );

  tof_rx_window #(.SEL_W(SEL_W)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (fire_evt),
    .len_cfg   (winlen_q),
    .win_open  (win_open),
    .win_first (win_first),
    .win_last  (win_last),
    .chan_sel  (rx_chan_sel)
  );

  tof_stream_gate #(.DW(DW), .SEL_W(SEL_W)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_open  (win_open),
    .win_first (win_first),
    .win_last  (win_last),
    .chan_sel  (rx_chan_sel),
    .samples   (s_samples),
    .tready    (m_axis_tready),
    .ovf_clr   (ovf_clr),
    .tvalid    (m_axis_tvalid),
    .tdata     (m_axis_tdata),
    .tlast     (m_axis_tlast),
    .tuser     (m_axis_tuser),
    .ovf       (ovf_flag),
    .drop      (beat_drop)
  );

endmodule

// File: rtl/tof_capture_ctrl_chk.sv
module tof_capture_ctrl_chk #(
  parameter int unsigned SEL_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             laser_trig,
  input logic             fire_evt,
  input logic             win_open,
  input logic             win_first,
  input logic             win_last,
  input logic             tvalid,
  input logic             tready,
  input logic             tlast,
  input logic [SEL_W-1:0] tuser,
  input logic [SEL_W-1:0] chan_sel,
  input logic             ovf_flag,
  input logic             ovf_clr,
  input logic             period_zero
);

  // R4
  fire_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_zero |-> !fire_evt);

  // R8
  holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> !fire_evt);

  // R3
  trig_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(laser_trig) |-> $past(fire_evt));

  // R5
  win_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tvalid) |-> $past(fire_evt));

  // R6
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlast |-> tvalid);

  // R6
  user_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tuser != '0) |-> win_first);

  // R7
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_open && !win_last) |=> $stable(chan_sel));

  // R7
  sel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_last |=> (chan_sel == SEL_W'($past(chan_sel) + 1'b1)));

  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tvalid && !tready) |=> ovf_flag);

  // R9
  ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

endmodule

bind tof_capture_ctrl tof_capture_ctrl_chk #(.SEL_W(SEL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .laser_trig  (laser_trig),
  .fire_evt    (fire_evt),
  .win_open    (win_open),
  .win_first   (win_first),
  .win_last    (win_last),
  .tvalid      (m_axis_tvalid),
  .tready      (m_axis_tready),
  .tlast       (m_axis_tlast),
  .tuser       (m_axis_tuser),
  .chan_sel    (rx_chan_sel),
  .ovf_flag    (ovf_flag),
  .ovf_clr     (ovf_clr),
  .period_zero (period_zero)
);

// File: tb/tof_capture_ctrl_bench.sv
`timescale 1ns/1ps
module tof_capture_ctrl_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_addr = '0;
  logic [15:0]  cfg_wdata = '0;
  logic [127:0] s_samples = '0;
  logic         m_axis_tready = 1'b1;
  logic         laser_trig;
  logic [1:0]   rx_chan_sel;
  logic [127:0] m_axis_tdata;
  logic         m_axis_tvalid;
  logic         m_axis_tlast;
  logic [1:0]   m_axis_tuser;
  logic         ovf_flag;

  int cyc = 0;
  int nchk = 0;
  int nerr = 0;
  int rmode = 0;
  logic [1:0] exp_sel = '0;

  typedef struct {
    int         c;
    logic       last;
    logic [1:0] user;
    logic [1:0] sel;
  } beat_t;

  beat_t bq[$];
  int    tq[$];

  tof_capture_ctrl u_tof_capture_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_addr      (cfg_addr),
    .cfg_wdata     (cfg_wdata),
    .s_samples     (s_samples),
    .laser_trig    (laser_trig),
    .rx_chan_sel   (rx_chan_sel),
    .m_axis_tdata  (m_axis_tdata),
    .m_axis_tvalid (m_axis_tvalid),
    .m_axis_tready (m_axis_tready),
    .m_axis_tlast  (m_axis_tlast),
    .m_axis_tuser  (m_axis_tuser),
    .ovf_flag      (ovf_flag)
  );

  initial forever #2.5 clk = ~clk;
  initial forever begin @(posedge clk); cyc = cyc + 1; end

  function automatic logic [127:0] samp(int c);
    logic [31:0] u;
    u = c;
    return {u * 32'h9E3779B1, ~u, u ^ 32'h5A5A5A5A, u};
  endfunction

  function automatic logic rdy(int c, int m);
    return (m == 0) || (c % 3 != 0);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, what, cyc, act, exp);
    end
  endtask

  // Input driver: samples and ready change only at the falling edge
  initial forever begin
    @(negedge clk);
    s_samples     = samp(cyc);
    m_axis_tready = rdy(cyc, rmode);
  end

  // Monitor: pops the scoreboard queues as the design produces results
  initial begin
    beat_t b;
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        while (tq.size() > 0 && tq[0] < cyc) begin
          chk(1'b0, "R3", "trigger cycle missed", 0, tq[0]);
          void'(tq.pop_front());
        end
        if (tq.size() > 0 && tq[0] == cyc) begin
          chk(laser_trig == 1'b1, "R3", "trigger level", laser_trig, 1);
          void'(tq.pop_front());
        end else if (laser_trig) begin
          chk(1'b0, "R2", "unexpected trigger", 1, 0);
        end
        while (bq.size() > 0 && bq[0].c < cyc) begin
          chk(1'b0, "R5", "beat missed", 0, bq[0].c);
          void'(bq.pop_front());
        end
        if (bq.size() > 0 && bq[0].c == cyc) begin
          b = bq.pop_front();
          chk(m_axis_tvalid == 1'b1, "R5", "tvalid in window", m_axis_tvalid, 1);
          chk(m_axis_tdata == samp(cyc), "R5", "tdata", m_axis_tdata, samp(cyc));
          chk(m_axis_tlast == b.last, "R6", "tlast", m_axis_tlast, b.last);
          chk(m_axis_tuser == b.user, "R6", "tuser", m_axis_tuser, b.user);
          chk(rx_chan_sel == b.sel, "R7", "select during window", rx_chan_sel, b.sel);
        end else if (m_axis_tvalid) begin
          chk(1'b0, "R5", "unexpected beat", 1, 0);
        end
      end
    end
  end

  // Called at a falling edge; returns at the next one with the write applied
  task automatic wr(logic [1:0] a, int d);
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = 16'(d);
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // Driver: configures a run of n shots and pushes the expected results
  task automatic run(int p, int w, int l, int n, int m, string tag);
    int  wp, iv, s0, slast;
    bit  eovf;
    rmode = m;
    wp    = (w >= p) ? p - 1 : w;
    iv    = (p > l + 1) ? p : l + 1;
    eovf  = 1'b0;
    wr(2'd1, w);
    wr(2'd2, l);
    wr(2'd0, p);
    s0 = cyc + 1;
    for (int i = 0; i < n; i++) begin
      int s;
      s = s0 + i * iv;
      for (int t = 0; t < wp; t++) tq.push_back(s + t);
      for (int k = 0; k < l; k++) begin
        beat_t e;
        e.c    = s + k;
        e.last = (k == l - 1);
        e.user = (k == 0) ? exp_sel : 2'd0;
        e.sel  = exp_sel;
        bq.push_back(e);
        if (!rdy(s + k, m)) eovf = 1'b1;
      end
      if (l > 0) exp_sel = exp_sel + 2'd1;
    end
    slast = s0 + (n - 1) * iv;
    while (cyc < slast) @(negedge clk);
    // R10: disabling during the last pulse must not cut it short
    wr(2'd0, 0);
    repeat (iv + l + 4) @(negedge clk);
    chk(bq.size() == 0, tag, "beats left unserved", bq.size(), 0);
    chk(tq.size() == 0, "R10", "trigger cycles left unserved", tq.size(), 0);
    chk(rx_chan_sel == exp_sel, "R7", "select after run", rx_chan_sel, exp_sel);
    chk(ovf_flag == eovf, "R9", "overflow flag after run", ovf_flag, eovf);
    if (eovf) begin
      wr(2'd3, 0);
      chk(ovf_flag == 1'b0, "R9", "overflow flag after clear", ovf_flag, 0);
    end
    rmode = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int bad;
    repeat (4) @(negedge clk);
    // R1: state during reset
    chk(laser_trig == 1'b0, "R1", "trigger in reset", laser_trig, 0);
    chk(m_axis_tvalid == 1'b0, "R1", "tvalid in reset", m_axis_tvalid, 0);
    chk(rx_chan_sel == 2'd0, "R1", "select in reset", rx_chan_sel, 0);
    chk(ovf_flag == 1'b0, "R1", "overflow in reset", ovf_flag, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(laser_trig == 1'b0 && m_axis_tvalid == 1'b0, "R1", "outputs after reset",
        {laser_trig, m_axis_tvalid}, 0);

    // R4: width and window set, period left at zero
    wr(2'd1, 3);
    wr(2'd2, 4);
    bad = 0;
    repeat (30) begin
      @(negedge clk);
      #1;
      if (laser_trig || m_axis_tvalid) bad++;
    end
    chk(bad == 0, "R4", "activity with period zero", bad, 0);
    @(negedge clk);

    run(10, 3, 4, 3, 0, "R2");   // basic period, width and window
    run(8, 12, 2, 2, 0, "R3");   // width clamped to period-1
    run(6, 2, 9, 3, 0, "R8");    // window longer than period: hold-off
    run(12, 4, 6, 3, 1, "R9");   // tready gaps: drops and overflow
    run(7, 2, 0, 3, 0, "R11");   // empty window
    run(5, 1, 1, 4, 0, "R5");    // single-beat windows, select wraps

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule